// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block gathers interrupt events from five sources and turns them into a single request to a byte-wide processor core. The sources are an external pin, a converter-reload strobe, a timer-1 overflow, a port-transition event and a base-timer overflow. Each source has a latched request flag and an enable bit, and software reads and writes both through a small register port. When a flag and its enable are both set while the core's global mask flag is clear, the block raises a request to the core.

Once the core acknowledges, the block takes over the entry sequence. It writes the program counter high byte, then the low byte, then the status byte into the stack page at a descending stack pointer. It pulses a stack-pointer decrement for each write and tells the core to set its mask flag. It then presents the address of the low byte of the winning source's vector; the high byte is at the next address.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, all request flags and enable bits read 0, irq_req_o is low, and no stack write, mask-set or vector strobe is given.
- R2: The external source (evt_i bit 0) sets its flag on a low-to-high change of the pin. Holding the pin high sets the flag only once, so a flag cleared while the pin stays high stays clear.
- R3: Each other source (evt_i bits 1 to 4) sets its flag in any cycle where its strobe is high at the clock edge.
- R4: With reg_sel_i=0, reg_rdata_o shows the flags, and with reg_sel_i=1 it shows the enables. Bit 0 is the external source, bit 1 reload, bit 2 timer-1, bit 3 port and bit 4 base timer. Bits 7:5 read 0.
- R5: A write with reg_sel_i=0 clears each flag whose data bit is 1 and leaves flags with a 0 data bit unchanged. An event arriving in the same cycle as its clear keeps the flag set.
- R6: In the idle state, irq_req_o is high exactly when some flag and its enable are both set and mask_i is low.
- R7: A flag whose enable is clear stays latched, and a request is raised once that enable is later set.
- R8: When several enabled flags are pending, the lowest bit number wins.
- R9: In the three cycles after an accepted acknowledge, the block gives stack writes in this order: address {8'h01, sp} with PC[15:8], then {8'h01, sp-1} with PC[7:0], then {8'h01, sp-2} with the status byte. PC, status and sp are sampled at the acknowledge, and sp_dec_o is high on each write.
- R10: set_mask_o is high in the status-push cycle. In the next cycle vec_valid_o is high and vec_addr_o holds the low-byte vector address: 16'hFFF8 for external, 16'hFFF6 for reload, 16'hFFF2 for timer-1, 16'hFFF0 for port and 16'hFFEE for base timer.
- R11: While an entry is in progress, busy_o is high, irq_req_o is low and irq_ack_i is ignored. An acknowledge is also ignored when no request is raised.
- R12: A write with reg_sel_i=1 replaces all five enable bits with data bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 5 | Source events; bit 0 is the external pin level, bits 1-4 are strobes |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 flags, 1 enables |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected register |
| mask_i | input | 1 | Global interrupt mask flag from the core |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_ack_i | input | 1 | Core accepts the request |
| pc_i | input | 16 | Program counter to be saved |
| status_i | input | 8 | Status register to be saved |
| sp_i | input | 8 | Current stack pointer |
| busy_o | output | 1 | Entry sequence in progress |
| mem_we_o | output | 1 | Stack write strobe |
| mem_addr_o | output | 16 | Stack write address |
| mem_wdata_o | output | 8 | Stack write data |
| sp_dec_o | output | 1 | Decrement the stack pointer |
| set_mask_o | output | 1 | Set the global mask flag |
| vec_valid_o | output | 1 | Vector address valid |
| vec_addr_o | output | 16 | Low-byte vector address of the winning source |

## Verification
The entry path is driven with one source at a time, which ties each source to its own vector address. All five are then raised together and removed one by one, which shows that the priority follows bit order and not arrival order. Events are timed against flag clears and enable writes in the same cycle, and a held-high pin is cleared while still high, which separates edge detection from level sensing and shows which update wins. Masked and disabled-but-pending cases show that the request is gated without the flag being lost. A reference model compares every output on every clock.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   localparam int unsigned NSRC   = 5;
   localparam int unsigned IDX_W  = $clog2(NSRC);
   localparam int unsigned ADDR_W = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PSH_HI,
      ST_PSH_LO,
      ST_PSH_ST,
      ST_VEC
   } entry_st_e;

   // low-byte vector address per source index; lower index = higher address
   function automatic logic [ADDR_W-1:0] vec_lo_addr(input logic [IDX_W-1:0] idx);
      case (idx)
         3'd0:    return 16'hFFF8;
         3'd1:    return 16'hFFF6;
         3'd2:    return 16'hFFF2;
         3'd3:    return 16'hFFF0;
         default: return 16'hFFEE;
      endcase
   endfunction
endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags
   import irq_vec_pkg::*;
#(
   parameter int unsigned        N_SRC     = NSRC,
   parameter int unsigned        DATA_W    = 8,
   parameter logic [N_SRC-1:0]   EDGE_MASK = 'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  evt_i,
   input  logic              wr_flag_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [N_SRC-1:0]  flag_o,
   output logic [N_SRC-1:0]  en_o
);
   logic [N_SRC-1:0] det_w;
   logic [N_SRC-1:0] flag_q;
   logic [N_SRC-1:0] en_q;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (EDGE_MASK[i]) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= evt_i[i];
         end
         assign det_w[i] = evt_i[i] & ~prev_q;
      end else begin : g_strobe
         assign det_w[i] = evt_i[i];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            flag_q[i] <= 1'b0;
         else if (det_w[i])
            flag_q[i] <= 1'b1;
         else if (wr_flag_i && wdata_i[i])
            flag_q[i] <= 1'b0;
      end

      assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
         det_w[i] |=> flag_q[i]);
      assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_flag_i && wdata_i[i] && !det_w[i]) |=> !flag_q[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       en_q <= '0;
      else if (wr_en_i) en_q <= wdata_i[N_SRC-1:0];
   end

   assert_en_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (en_q == $past(wdata_i[N_SRC-1:0])));

   assign flag_o = flag_q;
   assign en_o   = en_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned W     = 5,
   parameter int unsigned IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     req_i,
   output logic [W-1:0]     grant_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);
   always_comb begin
      grant_o = '0;
      idx_o   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            grant_o = '0;
            grant_o[i] = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end

   assign any_o = |req_i;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_vec_pkg::*;
#(
   parameter int unsigned        DATA_W     = 8,
   parameter int unsigned        SP_W       = 8,
   parameter int unsigned        PAGE_W     = ADDR_W - SP_W,
   parameter logic [PAGE_W-1:0]  STACK_PAGE = 'h01
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [IDX_W-1:0]    win_i,
   input  logic [2*DATA_W-1:0] pc_i,
   input  logic [DATA_W-1:0]   status_i,
   input  logic [SP_W-1:0]     sp_i,
   output logic                busy_o,
   output logic                mem_we_o,
   output logic [ADDR_W-1:0]   mem_addr_o,
   output logic [DATA_W-1:0]   mem_wdata_o,
   output logic                sp_dec_o,
   output logic                set_mask_o,
   output logic                vec_valid_o,
   output logic [ADDR_W-1:0]   vec_addr_o
);
   entry_st_e           st_q;
   logic [IDX_W-1:0]    win_q;
   logic [2*DATA_W-1:0] pc_q;
   logic [DATA_W-1:0]   status_q;
   logic [SP_W-1:0]     sp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         win_q    <= '0;
         pc_q     <= '0;
         status_q <= '0;
         sp_q     <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start_i) begin
               st_q     <= ST_PSH_HI;
               win_q    <= win_i;
               pc_q     <= pc_i;
               status_q <= status_i;
               sp_q     <= sp_i;
            end
            ST_PSH_HI: st_q <= ST_PSH_LO;
            ST_PSH_LO: st_q <= ST_PSH_ST;
            ST_PSH_ST: st_q <= ST_VEC;
            default:   st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_we_o    = 1'b0;
      mem_addr_o  = '0;
      mem_wdata_o = '0;
      sp_dec_o    = 1'b0;
      set_mask_o  = 1'b0;
      vec_valid_o = 1'b0;
      vec_addr_o  = '0;
      case (st_q)
         ST_PSH_HI: begin
            mem_we_o    = 1'b1;
            sp_dec_o    = 1'b1;
            mem_addr_o  = {STACK_PAGE, sp_q};
            mem_wdata_o = pc_q[2*DATA_W-1:DATA_W];
         end
         ST_PSH_LO: begin
            mem_we_o    = 1'b1;
            sp_dec_o    = 1'b1;
            mem_addr_o  = {STACK_PAGE, SP_W'(sp_q - SP_W'(1))};
            mem_wdata_o = pc_q[DATA_W-1:0];
         end
         ST_PSH_ST: begin
            mem_we_o    = 1'b1;
            sp_dec_o    = 1'b1;
            set_mask_o  = 1'b1;
            mem_addr_o  = {STACK_PAGE, SP_W'(sp_q - SP_W'(2))};
            mem_wdata_o = status_q;
         end
         ST_VEC: begin
            vec_valid_o = 1'b1;
            vec_addr_o  = vec_lo_addr(win_q);
         end
         default: ;
      endcase
   end

   assign busy_o = (st_q != ST_IDLE);

   assert_push_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PSH_HI) |=> (st_q == ST_PSH_LO));
   assert_push_descend_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PSH_LO) |-> (mem_addr_o == $past(mem_addr_o) - 16'd1));
   assert_vec_after_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_mask_o |=> vec_valid_o);
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
   import irq_vec_pkg::*;
#(
   parameter int unsigned       DATA_W     = 8,
   parameter int unsigned       SP_W       = 8,
   parameter logic [NSRC-1:0]   EDGE_MASK  = 5'b00001,
   parameter logic [7:0]        STACK_PAGE = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   evt_i,
   input  logic              reg_wr_i,
   input  logic              reg_sel_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              mask_i,
   output logic              irq_req_o,
   input  logic              irq_ack_i,
   input  logic [15:0]       pc_i,
   input  logic [DATA_W-1:0] status_i,
   input  logic [SP_W-1:0]   sp_i,
   output logic              busy_o,
   output logic              mem_we_o,
   output logic [15:0]       mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              sp_dec_o,
   output logic              set_mask_o,
   output logic              vec_valid_o,
   output logic [15:0]       vec_addr_o
);
   localparam int unsigned PAGE_W = ADDR_W - SP_W;

   if (DATA_W != 8) begin : g_bad_data_w
      $error("irq_vec_ctrl: DATA_W must be 8 for byte-wide stack pushes");
   end
   if (SP_W != 8) begin : g_bad_sp_w
      $error("irq_vec_ctrl: SP_W must be 8 with an 8-bit stack page");
   end

   logic [NSRC-1:0]  flag_w, en_w, pend_w, grant_w;
   logic [IDX_W-1:0] win_w;
   logic             any_w;
   logic             start_w;

   irq_src_flags #(
      .N_SRC    (NSRC),
      .DATA_W   (DATA_W),
      .EDGE_MASK(EDGE_MASK)
   ) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i),
      .wr_flag_i(reg_wr_i & ~reg_sel_i),
      .wr_en_i  (reg_wr_i & reg_sel_i),
      .wdata_i  (reg_wdata_i),
      .flag_o   (flag_w),
      .en_o     (en_w)
   );

   assign pend_w = flag_w & en_w;

   irq_prio_enc #(
      .W    (NSRC),
      .IDX_W(IDX_W)
   ) u_prio (
      .req_i  (pend_w),
      .grant_o(grant_w),
      .idx_o  (win_w),
      .any_o  (any_w)
   );

   assign irq_req_o = any_w & ~mask_i & ~busy_o;
   assign start_w   = irq_req_o & irq_ack_i;

   irq_entry_seq #(
      .DATA_W    (DATA_W),
      .SP_W      (SP_W),
      .PAGE_W    (PAGE_W),
      .STACK_PAGE(STACK_PAGE[PAGE_W-1:0])
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_w),
      .win_i      (win_w),
      .pc_i       (pc_i),
      .status_i   (status_i),
      .sp_i       (sp_i),
      .busy_o     (busy_o),
      .mem_we_o   (mem_we_o),
      .mem_addr_o (mem_addr_o),
      .mem_wdata_o(mem_wdata_o),
      .sp_dec_o   (sp_dec_o),
      .set_mask_o (set_mask_o),
      .vec_valid_o(vec_valid_o),
      .vec_addr_o (vec_addr_o)
   );

   assign reg_rdata_o = reg_sel_i ? DATA_W'(en_w) : DATA_W'(flag_w);

   assert_req_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> (!mask_i && (flag_w & en_w) != '0));
   assert_req_low_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !irq_req_o);
   assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_w) && ((grant_w & ~pend_w) == '0));
endmodule

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  evt = '0;
   logic        wr = 1'b0, sel = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        mask = 1'b0;
   logic        req, ack = 1'b0;
   logic [15:0] pc = 16'h1234;
   logic [7:0]  status = 8'h20;
   logic [7:0]  sp = 8'hFF;
   logic        busy, we, spdec, smask, vvalid;
   logic [15:0] maddr, vaddr;
   logic [7:0]  mdata;

   int n_chk = 0, n_fail = 0;
   bit started = 0;

   always #10 clk = ~clk;

   irq_vec_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr), .reg_sel_i(sel),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mask_i(mask), .irq_req_o(req),
      .irq_ack_i(ack), .pc_i(pc), .status_i(status), .sp_i(sp), .busy_o(busy),
      .mem_we_o(we), .mem_addr_o(maddr), .mem_wdata_o(mdata), .sp_dec_o(spdec),
      .set_mask_o(smask), .vec_valid_o(vvalid), .vec_addr_o(vaddr)
   );

   // ---------------- behavioural reference model ----------------
   bit   m_flag[5], m_en[5];
   bit   m_prev;
   int   m_st;          // 0 idle, 1..3 pushes, 4 vector
   int   m_win;
   int   m_pc, m_stat, m_sp;
   int   vec_tab[5] = '{16'hFFF8, 16'hFFF6, 16'hFFF2, 16'hFFF0, 16'hFFEE};

   function automatic int m_winner();
      for (int i = 0; i < 5; i++) if (m_flag[i] && m_en[i]) return i;
      return -1;
   endfunction

   function automatic bit m_req();
      return (m_st == 0) && (m_winner() >= 0) && !mask;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 5; i++) begin m_flag[i] = 0; m_en[i] = 0; end
         m_prev = 1; m_st = 0; m_win = 0; m_pc = 0; m_stat = 0; m_sp = 0;
      end else begin
         bit take;
         take = m_req() && ack;
         if (take) begin
            m_win = m_winner(); m_pc = pc; m_stat = status; m_sp = sp;
         end
         if (m_st == 0) m_st = take ? 1 : 0;
         else if (m_st == 4) m_st = 0;
         else m_st = m_st + 1;
         for (int i = 0; i < 5; i++) begin
            bit hit;
            hit = (i == 0) ? (evt[0] && !m_prev) : evt[i];
            if (wr && !sel && wdata[i]) m_flag[i] = 0;
            if (hit) m_flag[i] = 1;
         end
         if (wr && sel) for (int i = 0; i < 5; i++) m_en[i] = wdata[i];
         m_prev = evt[0];
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (started && rst_n) begin
         int ex_rd;
         ex_rd = 0;
         for (int i = 0; i < 5; i++) ex_rd[i] = sel ? m_en[i] : m_flag[i];
         chk("R4 rdata", rdata, ex_rd);
         chk("R6 irq_req", req, m_req());
         chk("R11 busy", busy, m_st != 0);
         chk("R9 mem_we", we, (m_st >= 1 && m_st <= 3));
         chk("R9 sp_dec", spdec, (m_st >= 1 && m_st <= 3));
         if (m_st >= 1 && m_st <= 3) begin
            chk("R9 mem_addr", maddr, {8'h01, 8'((m_sp - (m_st - 1)) & 8'hFF)});
            chk("R9 mem_data", mdata,
                (m_st == 1) ? ((m_pc >> 8) & 8'hFF) : (m_st == 2) ? (m_pc & 8'hFF) : m_stat);
         end
         chk("R10 set_mask", smask, m_st == 3);
         chk("R10 vec_valid", vvalid, m_st == 4);
         if (m_st == 4) chk("R10 vec_addr", vaddr, vec_tab[m_win]);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step(); @(posedge clk); #2; endtask

   task automatic reg_write(input bit s, input logic [7:0] d);
      wr = 1; sel = s; wdata = d; step(); wr = 0; wdata = '0;
   endtask

   task automatic pulse(input logic [4:0] m);
      evt = evt | m; step(); evt = evt & ~m;
   endtask

   task automatic read_chk(input bit s, input int exp, input string tag);
      sel = s; @(negedge clk); chk(tag, rdata, exp); step();
   endtask

   // accept one entry and check the vector it delivers
   task automatic take_irq(input int exp_vec, input string tag);
      @(negedge clk); chk({tag, " request"}, req, 1);
      #8; ack = 1; step();
      step(); ack = 0;          // ack held into the busy window: ignored (R11)
      repeat (2) @(negedge clk);
      #1 @(negedge clk);
      chk({tag, " vector"}, vaddr, exp_vec);
      step();
   endtask

   initial begin
      fork
         begin
            repeat (100000) @(posedge clk);
            n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
         end
      join_none

      repeat (3) step();
      rst_n = 1; started = 1;
      // R1: reset state
      @(negedge clk);
      chk("R1 flags", rdata, 0); chk("R1 req", req, 0); chk("R1 we", we, 0);
      step();
      read_chk(1, 0, "R1 enables");

      // R2: external edge; hold high, clear, stays clear
      evt[0] = 1; step();
      read_chk(0, 8'h01, "R2 edge sets");
      reg_write(0, 8'h01);
      repeat (2) step();
      read_chk(0, 8'h00, "R2 held level no reset");
      evt[0] = 0; step();

      // R3: each strobe
      for (int i = 1; i < 5; i++) begin
         pulse(5'(1 << i));
         read_chk(0, 1 << i, "R3 strobe");
         reg_write(0, 8'(1 << i));
      end

      // R12/R4: enable overwrite, upper bits read zero
      reg_write(1, 8'hFF);
      read_chk(1, 8'h1F, "R12 R4 enables all");
      reg_write(1, 8'h0A);
      read_chk(1, 8'h0A, "R12 overwrite");

      // R5: write 0 no effect, same-cycle event wins
      pulse(5'b11110);
      reg_write(0, 8'h00);
      read_chk(0, 8'h1E, "R5 zero write");
      evt[2] = 1; reg_write(0, 8'h1E); evt[2] = 0;
      read_chk(0, 8'h04, "R5 event wins");
      reg_write(0, 8'hFF);
      read_chk(0, 8'h00, "R5 cleared");

      // R7: pending but disabled, then enabled
      reg_write(1, 8'h00);
      pulse(5'b10000);
      @(negedge clk); chk("R7 disabled no req", req, 0); step();
      // R6: mask blocks
      mask = 1; reg_write(1, 8'h10);
      @(negedge clk); chk("R6 masked", req, 0); step();
      // R11: ack without request ignored
      ack = 1; step(); ack = 0;
      @(negedge clk); chk("R11 stray ack", busy, 0); step();
      mask = 0;
      pc = 16'hBEEF; status = 8'hA5; sp = 8'h80;
      take_irq(16'hFFEE, "R7 R10 base");
      reg_write(0, 8'hFF);

      // R8: all five pending, removed one at a time
      reg_write(1, 8'h1F);
      mask = 1;
      pulse(5'b11110); evt[0] = 1; step(); evt[0] = 0; step();
      mask = 0;
      for (int i = 0; i < 5; i++) begin
         pc = 16'h0100 * i + 16'h42; sp = 8'(8'h01 + i); status = 8'(i);
         take_irq(vec_tab[i], "R8 R9 priority");
         reg_write(0, 8'(1 << i));
      end

      repeat (4) step();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule